// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block carries out two drawing operations on a linear, byte-addressed framebuffer: painting a rectangle with a solid colour, and moving a rectangle from one place on the screen to another. The screen geometry comes from two configuration inputs, the number of bytes in a pixel (1 to 4) and the screen width in pixels. Their product is the distance in bytes from one row to the next. A pixel at column x and row y sits at byte address bpp*x + pitch*y. All framebuffer traffic goes through a single byte-wide port that either reads or writes in a given cycle. Read data returns one cycle after the read.

A fill first writes the destination's top row by cycling through the colour word's low bytes. It then copies that row into each of the rows below it. A copy moves the region one row at a time. The engine chooses the row order and the byte order within a row so that a region that overlaps its own source is moved without corrupting itself. When an operation ends, the engine issues a one-cycle record of the destination rectangle so that a display path can redraw that area. Clipping against the screen, display refresh and command decoding are handled elsewhere. Callers must keep rectangles inside the screen.

Top module: `rect_engine`

## Requirements
- R1: The byte address of pixel (x, y) is bpp*x + pitch*y, where pitch = bpp * cfg_width. The first byte that an operation writes lies at the destination row and column that its traversal order starts from.
- R2: A fill writes byte k of each destination line with colour byte (k mod bpp). Colour byte 0 is cmd_color[7:0], byte 1 is cmd_color[15:8], and so on.
- R3: After a fill, each of the h destination lines holds the same byte pattern as the first line.
- R4: A copy moves bpp*w bytes on each of h lines, and performs exactly bpp*w*h memory writes.
- R5: When the destination row is greater than the source row, lines are processed from row +h-1 upward. An overlapping downward copy therefore gives the same result as copying through a temporary buffer.
- R6: When the destination column is greater than the source column, bytes within a line are moved from the highest address down. An overlapping rightward copy on the same rows therefore gives the temporary-buffer result.
- R7: When each operation completes, dirty_valid is high for exactly one cycle and carries the destination x, y, w and h. No other dirty record is produced.
- R8: An operation with zero width or zero height performs no memory access. It posts its dirty record in the cycle right after it is accepted.
- R9: busy rises in the cycle after a command is accepted and stays high up to and including the dirty cycle. The busy time is 2*bpp*w*h+1 cycles for a copy and bpp*w + 2*bpp*w*(h-1) + 1 cycles for a fill. cmd_valid is ignored while busy is high.
- R10: Bytes outside the destination rectangle are never modified. The memory port is quiet while busy is low.
- R11: mem_re and mem_we are never high together. Each read is followed in the next cycle by the write of the byte that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_width | input | COORD_W | Screen width in pixels |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 1 | 0 = fill, 1 = copy |
| cmd_color | input | COLOR_W | Fill colour |
| cmd_sx | input | COORD_W | Source column (copy) |
| cmd_sy | input | COORD_W | Source row (copy) |
| cmd_dx | input | COORD_W | Destination column |
| cmd_dy | input | COORD_W | Destination row |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in lines |
| busy | output | 1 | Operation in progress |
| mem_addr | output | ADDR_W | Framebuffer byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| dirty_valid | output | 1 | Dirty record strobe |
| dirty_x | output | COORD_W | Dirty rectangle column |
| dirty_y | output | COORD_W | Dirty rectangle row |
| dirty_w | output | COORD_W | Dirty rectangle width |
| dirty_h | output | COORD_W | Dirty rectangle height |

## Verification
The hardest cases to reach are self-overlapping copies, because the traversal order only matters there. If the order is wrong, a byte is overwritten before it has been read. The stimulus places source and destination a few pixels apart in each direction: down-right, down-left, up-left, and the same rows shifted right. Each result is compared with a model that buffers the whole source before writing, and the bench also checks the address of the first write. A second case that is hard to reach is a command that arrives while the engine is busy. The bench holds cmd_valid high with a different command throughout one operation and confirms that the framebuffer and the dirty records show no trace of it.

// File: rtl/rect_pkg.sv
package rect_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FILL = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_DONE = 3'd4
  } rect_state_e;

  localparam logic OP_FILL = 1'b0;
  localparam logic OP_COPY = 1'b1;

endpackage

// File: rtl/rect_pattern.sv
module rect_pattern #(
  parameter int COLOR_W = 32,
  localparam int NB     = COLOR_W / 8,
  localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [COLOR_W-1:0] color,
  input  logic [IDX_W-1:0]   idx,
  output logic [7:0]         byte_out
);

  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = color[8*g +: 8];
  end

  assign byte_out = lanes[idx];

endmodule

// File: rtl/rect_addr_gen.sv
module rect_addr_gen #(
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 16,
  localparam int LB_W   = COORD_W + 3
) (
  input  logic [2:0]         bpp,
  input  logic [LB_W-1:0]    pitch,
  input  logic [LB_W-1:0]    line_bytes,
  input  logic [COORD_W-1:0] sx,
  input  logic [COORD_W-1:0] sy,
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  input  logic [COORD_W-1:0] h,
  input  logic [COORD_W-1:0] line_cnt,
  input  logic [LB_W-1:0]    byte_cnt,
  input  logic               bottom_up,
  input  logic               descending,
  input  logic               fill_mode,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr
);

  // Byte address of offset k within the line that starts at pixel (x, y).
  function automatic logic [ADDR_W-1:0] byte_addr(
    input logic [2:0]         f_bpp,
    input logic [LB_W-1:0]    f_pitch,
    input logic [COORD_W-1:0] f_x,
    input logic [COORD_W-1:0] f_y,
    input logic [LB_W-1:0]    f_k
  );
    return ADDR_W'(f_bpp) * ADDR_W'(f_x) + ADDR_W'(f_pitch) * ADDR_W'(f_y) + ADDR_W'(f_k);
  endfunction

  logic [COORD_W-1:0] row_ofs;
  logic [COORD_W-1:0] src_row;
  logic [COORD_W-1:0] dst_row;
  logic [LB_W-1:0]    col_ofs;

  always_comb begin
    row_ofs = bottom_up ? (h - COORD_W'(1) - line_cnt) : line_cnt;
    src_row = fill_mode ? sy : (sy + row_ofs);
    dst_row = dy + row_ofs;
    col_ofs = descending ? (line_bytes - LB_W'(1) - byte_cnt) : byte_cnt;
  end

  assign src_addr = byte_addr(bpp, pitch, sx, src_row, col_ofs);
  assign dst_addr = byte_addr(bpp, pitch, dx, dst_row, col_ofs);

endmodule

// File: rtl/rect_ctrl.sv
module rect_ctrl
  import rect_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int COLOR_W = 32,
  localparam int LB_W   = COORD_W + 3,
  localparam int NB     = COLOR_W / 8,
  localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_bpp,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic               cmd_valid,
  input  logic               cmd_op,
  input  logic [COLOR_W-1:0] cmd_color,
  input  logic [COORD_W-1:0] cmd_sx,
  input  logic [COORD_W-1:0] cmd_sy,
  input  logic [COORD_W-1:0] cmd_dx,
  input  logic [COORD_W-1:0] cmd_dy,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  output rect_state_e        state,
  output logic               accept,
  output logic               last_byte,
  output logic               last_line,
  output logic [COORD_W-1:0] line_cnt,
  output logic [LB_W-1:0]    byte_cnt,
  output logic [IDX_W-1:0]   pat_idx,
  output logic [2:0]         r_bpp,
  output logic [LB_W-1:0]    r_pitch,
  output logic [LB_W-1:0]    r_lb,
  output logic [COLOR_W-1:0] r_color,
  output logic [COORD_W-1:0] r_sx,
  output logic [COORD_W-1:0] r_sy,
  output logic [COORD_W-1:0] r_dx,
  output logic [COORD_W-1:0] r_dy,
  output logic [COORD_W-1:0] r_w,
  output logic [COORD_W-1:0] r_h,
  output logic               r_fill,
  output logic               r_bottom_up,
  output logic               r_desc
);

  logic zero_size;
  logic pat_wrap;

  assign accept    = cmd_valid && (state == ST_IDLE);
  assign zero_size = (cmd_w == '0) || (cmd_h == '0);
  assign last_byte = (byte_cnt == r_lb - LB_W'(1));
  assign last_line = (line_cnt == r_h - COORD_W'(1));
  assign pat_wrap  = ({1'b0, pat_idx} == (IDX_W+1)'(r_bpp - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      line_cnt    <= '0;
      byte_cnt    <= '0;
      pat_idx     <= '0;
      r_bpp       <= 3'd1;
      r_pitch     <= '0;
      r_lb        <= '0;
      r_color     <= '0;
      r_sx        <= '0;
      r_sy        <= '0;
      r_dx        <= '0;
      r_dy        <= '0;
      r_w         <= '0;
      r_h         <= '0;
      r_fill      <= 1'b0;
      r_bottom_up <= 1'b0;
      r_desc      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            r_bpp       <= cfg_bpp;
            r_pitch     <= LB_W'(cfg_bpp) * LB_W'(cfg_width);
            r_lb        <= LB_W'(cfg_bpp) * LB_W'(cmd_w);
            r_color     <= cmd_color;
            r_dx        <= cmd_dx;
            r_dy        <= cmd_dy;
            r_w         <= cmd_w;
            r_h         <= cmd_h;
            r_fill      <= (cmd_op == OP_FILL);
            // a fill replicates its own first line: source is the destination
            r_sx        <= (cmd_op == OP_FILL) ? cmd_dx : cmd_sx;
            r_sy        <= (cmd_op == OP_FILL) ? cmd_dy : cmd_sy;
            r_bottom_up <= (cmd_op == OP_COPY) && (cmd_dy > cmd_sy);
            r_desc      <= (cmd_op == OP_COPY) && (cmd_dx > cmd_sx);
            line_cnt    <= '0;
            byte_cnt    <= '0;
            pat_idx     <= '0;
            if (zero_size)              state <= ST_DONE;
            else if (cmd_op == OP_FILL) state <= ST_FILL;
            else                        state <= ST_RD;
          end
        end
        ST_FILL: begin
          pat_idx <= pat_wrap ? '0 : pat_idx + IDX_W'(1);
          if (last_byte) begin
            byte_cnt <= '0;
            if (r_h == COORD_W'(1)) begin
              state <= ST_DONE;
            end else begin
              line_cnt <= COORD_W'(1);
              state    <= ST_RD;
            end
          end else begin
            byte_cnt <= byte_cnt + LB_W'(1);
          end
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (last_byte) begin
            byte_cnt <= '0;
            if (last_line) begin
              state <= ST_DONE;
            end else begin
              line_cnt <= line_cnt + COORD_W'(1);
              state    <= ST_RD;
            end
          end else begin
            byte_cnt <= byte_cnt + LB_W'(1);
            state    <= ST_RD;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rect_engine.sv
module rect_engine
  import rect_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 16,
  parameter int COLOR_W = 32,
  localparam int LB_W   = COORD_W + 3,
  localparam int NB     = COLOR_W / 8,
  localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_bpp,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic               cmd_valid,
  input  logic               cmd_op,
  input  logic [COLOR_W-1:0] cmd_color,
  input  logic [COORD_W-1:0] cmd_sx,
  input  logic [COORD_W-1:0] cmd_sy,
  input  logic [COORD_W-1:0] cmd_dx,
  input  logic [COORD_W-1:0] cmd_dy,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  output logic               busy,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               dirty_valid,
  output logic [COORD_W-1:0] dirty_x,
  output logic [COORD_W-1:0] dirty_y,
  output logic [COORD_W-1:0] dirty_w,
  output logic [COORD_W-1:0] dirty_h
);

  rect_state_e        state;
  logic               accept_evt;
  logic               last_byte_evt;
  logic               last_line_evt;
  logic [COORD_W-1:0] line_cnt;
  logic [LB_W-1:0]    byte_cnt;
  logic [IDX_W-1:0]   pat_idx;
  logic [2:0]         r_bpp;
  logic [LB_W-1:0]    r_pitch;
  logic [LB_W-1:0]    r_lb;
  logic [COLOR_W-1:0] r_color;
  logic [COORD_W-1:0] r_sx, r_sy, r_dx, r_dy, r_w, r_h;
  logic               r_fill, r_bottom_up, r_desc;
  logic [ADDR_W-1:0]  src_addr;
  logic [ADDR_W-1:0]  dst_addr;
  logic [7:0]         pat_byte;

  rect_ctrl #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_bpp(cfg_bpp), .cfg_width(cfg_width),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_color(cmd_color),
    .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy),
    .cmd_w(cmd_w), .cmd_h(cmd_h),
    .state(state), .accept(accept_evt),
    .last_byte(last_byte_evt), .last_line(last_line_evt),
    .line_cnt(line_cnt), .byte_cnt(byte_cnt), .pat_idx(pat_idx),
    .r_bpp(r_bpp), .r_pitch(r_pitch), .r_lb(r_lb), .r_color(r_color),
    .r_sx(r_sx), .r_sy(r_sy), .r_dx(r_dx), .r_dy(r_dy), .r_w(r_w), .r_h(r_h),
    .r_fill(r_fill), .r_bottom_up(r_bottom_up), .r_desc(r_desc)
  );

  rect_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_addr (
    .bpp(r_bpp), .pitch(r_pitch), .line_bytes(r_lb),
    .sx(r_sx), .sy(r_sy), .dx(r_dx), .dy(r_dy), .h(r_h),
    .line_cnt(line_cnt), .byte_cnt(byte_cnt),
    .bottom_up(r_bottom_up), .descending(r_desc), .fill_mode(r_fill),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  rect_pattern #(.COLOR_W(COLOR_W)) u_pat (
    .color(r_color), .idx(pat_idx), .byte_out(pat_byte)
  );

  assign busy        = (state != ST_IDLE);
  assign mem_re      = (state == ST_RD);
  assign mem_we      = (state == ST_FILL) || (state == ST_WR);
  assign mem_addr    = (state == ST_RD) ? src_addr : dst_addr;
  assign mem_wdata   = (state == ST_FILL) ? pat_byte : mem_rdata;
  assign dirty_valid = (state == ST_DONE);
  assign dirty_x     = r_dx;
  assign dirty_y     = r_dy;
  assign dirty_w     = r_w;
  assign dirty_h     = r_h;

endmodule

// File: rtl/rect_engine_checker.sv
module rect_engine_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic mem_we,
  input logic mem_re,
  input logic dirty_valid,
  input logic accept
);

  assert_no_rw_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && !mem_re));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  assert_dirty_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> busy);

  assert_dirty_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |=> (!busy && !dirty_valid));

  assert_busy_needs_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  assert_accept_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

endmodule

bind rect_engine rect_engine_checker u_rect_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .mem_we(mem_we), .mem_re(mem_re), .dirty_valid(dirty_valid),
  .accept(accept_evt)
);

// File: tb/rect_engine_bench.sv
module rect_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int COORD_W    = 10;
  localparam int ADDR_W     = 16;
  localparam int COLOR_W    = 32;
  localparam int MEMSZ      = 2048;
  localparam int SCR_W      = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [2:0]         cfg_bpp = 3'd1;
  logic [COORD_W-1:0] cfg_width = COORD_W'(SCR_W);
  logic               cmd_valid = 1'b0;
  logic               cmd_op = 1'b0;
  logic [COLOR_W-1:0] cmd_color = '0;
  logic [COORD_W-1:0] cmd_sx = '0, cmd_sy = '0, cmd_dx = '0, cmd_dy = '0, cmd_w = '0, cmd_h = '0;
  logic               busy;
  logic [ADDR_W-1:0]  mem_addr;
  logic               mem_we, mem_re;
  logic [7:0]         mem_wdata;
  logic [7:0]         mem_rdata;
  logic               dirty_valid;
  logic [COORD_W-1:0] dirty_x, dirty_y, dirty_w, dirty_h;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct { int x; int y; int w; int h; } rec_t;
  rec_t exp_q[$];

  logic [7:0] mem     [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_engine #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_rect_engine (
    .clk(clk), .rst_n(rst_n), .cfg_bpp(cfg_bpp), .cfg_width(cfg_width),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_color(cmd_color),
    .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .busy(busy),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dirty_valid(dirty_valid), .dirty_x(dirty_x), .dirty_y(dirty_y),
    .dirty_w(dirty_w), .dirty_h(dirty_h)
  );

  // framebuffer model: synchronous read, data one cycle after mem_re
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= 8'(i * 7 + 3);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[10:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every dirty record must match the oldest expected one (R7)
  always @(negedge clk) begin
    if (rst_n && dirty_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected dirty record x", longint'(dirty_x), -1);
      end else begin
        rec_t e;
        e = exp_q.pop_front();
        chk(dirty_x == COORD_W'(e.x) && dirty_y == COORD_W'(e.y) &&
            dirty_w == COORD_W'(e.w) && dirty_h == COORD_W'(e.h),
            "R7", "dirty rectangle x*1e9+y*1e6+w*1e3+h",
            longint'(dirty_x)*1000000000 + longint'(dirty_y)*1000000 + longint'(dirty_w)*1000 + longint'(dirty_h),
            longint'(e.x)*1000000000 + longint'(e.y)*1000000 + longint'(e.w)*1000 + longint'(e.h));
      end
    end
  end

  // driver: updates the reference image, pushes the expected record, runs the command
  task automatic run_op(input bit op, input logic [31:0] col, input int bpp,
                        input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input bit poke, input string tag);
    int pitch, lb, exp_cyc, cyc, wr, first_addr, exp_first, bad;
    bit seen, both;
    logic [7:0] tmp[$];
    rec_t r;
    pitch = bpp * SCR_W;
    lb    = bpp * w;
    if (w > 0 && h > 0) begin
      if (op == 1'b0) begin
        for (int row = 0; row < h; row++)
          for (int k = 0; k < lb; k++)
            exp_mem[bpp*dx + pitch*(dy+row) + k] = col[8*(k % bpp) +: 8];
      end else begin
        for (int row = 0; row < h; row++)
          for (int k = 0; k < lb; k++)
            tmp.push_back(exp_mem[bpp*sx + pitch*(sy+row) + k]);
        for (int row = 0; row < h; row++)
          for (int k = 0; k < lb; k++)
            exp_mem[bpp*dx + pitch*(dy+row) + k] = tmp.pop_front();
      end
    end
    r.x = dx; r.y = dy; r.w = w; r.h = h;
    exp_q.push_back(r);
    if (w == 0 || h == 0)  exp_cyc = 1;
    else if (op == 1'b0)   exp_cyc = lb + 2*lb*(h-1) + 1;
    else                   exp_cyc = 2*lb*h + 1;
    if (op == 1'b0) exp_first = bpp*dx + pitch*dy;
    else exp_first = bpp*dx + pitch*((dy > sy) ? dy + h - 1 : dy) + ((dx > sx) ? lb - 1 : 0);

    @(negedge clk);
    cfg_bpp   = 3'(bpp);
    cmd_op    = op;
    cmd_color = col;
    cmd_sx = COORD_W'(sx); cmd_sy = COORD_W'(sy);
    cmd_dx = COORD_W'(dx); cmd_dy = COORD_W'(dy);
    cmd_w  = COORD_W'(w);  cmd_h  = COORD_W'(h);
    cmd_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      // a different fill held on the command input the whole time busy is high
      cmd_op = 1'b0; cmd_color = 32'hFFFFFFFF;
      cmd_dx = '0; cmd_dy = '0; cmd_w = COORD_W'(2); cmd_h = COORD_W'(2);
    end else begin
      cmd_valid = 1'b0;
    end
    chk(busy == 1'b1, "R9", {tag, " busy after accept"}, longint'(busy), 1);
    cyc = 0; wr = 0; seen = 1'b0; first_addr = -1; both = 1'b0;
    while (busy) begin
      cyc++;
      if (mem_we && mem_re) both = 1'b1;
      if (mem_we) begin
        wr++;
        if (!seen) begin seen = 1'b1; first_addr = int'(mem_addr); end
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(cyc == exp_cyc, "R9", {tag, " busy cycles"}, cyc, exp_cyc);
    chk(!both, "R11", {tag, " read and write together"}, longint'(both), 0);
    if (w == 0 || h == 0) begin
      chk(wr == 0, "R8", {tag, " writes on empty rectangle"}, wr, 0);
    end else begin
      chk(wr == lb*h, "R4", {tag, " write count"}, wr, lb*h);
      chk(first_addr == exp_first, "R1", {tag, " first write address"}, first_addr, exp_first);
    end
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) begin
      if (bad == 0) $display("  first mismatch at byte %0d: %0h vs %0h", i, mem[i], exp_mem[i]);
      bad++;
    end
    chk(bad == 0, "R10", {tag, " framebuffer image mismatching bytes"}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) exp_mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && dirty_valid == 1'b0, "R9", "reset: busy/dirty", longint'({busy, dirty_valid}), 0);
    chk(mem_we == 1'b0 && mem_re == 1'b0, "R10", "reset: memory strobes", longint'({mem_we, mem_re}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(1'b0, 32'h11223344, 4, 0, 0, 2, 1, 3, 2, 1'b0, "R2 R3 fill bpp4");
    run_op(1'b0, 32'hA1B2C3D4, 3, 0, 0, 1, 4, 5, 3, 1'b0, "R2 R3 fill bpp3");
    run_op(1'b0, 32'h0000005A, 1, 0, 0, 15, 0, 1, 1, 1'b0, "R2 fill single pixel");
    run_op(1'b1, 32'h0, 2, 0, 0, 8, 6, 4, 3, 1'b0, "R4 copy disjoint");
    run_op(1'b1, 32'h0, 2, 1, 2, 2, 4, 5, 4, 1'b0, "R5 R6 copy down-right overlap");
    run_op(1'b1, 32'h0, 1, 2, 8, 5, 8, 8, 2, 1'b0, "R6 copy same rows right");
    run_op(1'b1, 32'h0, 4, 4, 5, 2, 3, 6, 4, 1'b0, "R4 copy up-left overlap");
    run_op(1'b1, 32'h0, 3, 5, 9, 3, 10, 4, 2, 1'b0, "R5 copy down-left overlap");
    run_op(1'b0, 32'hDEADBEEF, 2, 0, 0, 3, 3, 0, 4, 1'b0, "R8 fill zero width");
    run_op(1'b1, 32'h0, 2, 1, 1, 6, 6, 3, 0, 1'b0, "R8 copy zero height");
    run_op(1'b0, 32'h00C0FFEE, 2, 0, 0, 9, 11, 3, 2, 1'b1, "R9 fill with command held");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "dirty records outstanding", exp_q.size(), 0);
    chk(busy == 1'b0, "R9", "idle after held command removed", longint'(busy), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule